// File: doc/BRIEF.md
# Self-Timed Comparator Clock Generator

This block produces the comparator phase clock for a successive-approximation converter that has no fast conversion clock of its own. The comparator clock `cmp_clk` is high for precharge and low for compare. During precharge the comparator holds both of its outputs high. In compare, one output falls, and that fall is the decision. The block forms a decision flag `valid` as the NAND of the two comparator outputs. When the flag rises, the block puts the comparator back into precharge. Once the comparator has recovered and the flag clears, the block releases the comparator into the next compare, as long as the sequencer still asks for another bit.

A conversion starts from idle with a one-cycle `conv_start`. A track phase of fixed length follows, and during it the comparator stays in precharge. The compare phase is never shorter than a minimum window. This window stands in for an analog delay of about 250 ns, so a decision cannot be accepted at the same moment the compare phase opens. The comparator outputs are asynchronous to the system clock and pass through a synchronizer whose depth is a parameter. If no decision arrives within a bounded number of cycles, the block aborts the conversion, returns the comparator to precharge and flags a timeout.

Top module: `cmpclk_gen`

## Requirements
- R1: During reset and while idle, `cmp_clk` is 1, `valid` is 0 and `timeout` is 0.
- R2: After `conv_start` is sampled high in idle, `cmp_clk` stays 1 for exactly TRACK_CYC cycles and then falls to 0.
- R3: `valid` is the NAND of the two comparator outputs taken after SYNC_STAGES register stages. During compare it is masked to 0 until the compare phase has lasted MIN_CMP_CYC-1 cycles. During precharge it is unmasked.
- R4: When a comparator output falls in compare cycle k (counted from 0), `cmp_clk` stays low for exactly max(k+SYNC_STAGES+1, MIN_CMP_CYC) cycles. It rises in the cycle after `valid` is first seen.
- R5: In precharge, the first cycle in which `valid` is 0 with `bit_en` = 1 starts the next compare in the following cycle. If the outputs recover in precharge cycle r, the precharge lasts r+SYNC_STAGES+1 cycles.
- R6: If `bit_en` is 0 in that cycle, the block returns to idle and `cmp_clk` stays 1.
- R7: If `valid` has not risen by compare cycle TMO_CYC-1, `cmp_clk` rises after TMO_CYC low cycles, `timeout` pulses high for exactly one cycle and the block goes idle. A `valid` that rises in cycle TMO_CYC-1 is still accepted, with no timeout.
- R8: `conv_start` has no effect outside idle. A pulse during compare does not change the length of that compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_start | input | 1 | Starts a conversion when the block is idle |
| bit_en | input | 1 | Sequencer request for another bit after the current one |
| cmp_p | input | 1 | Comparator output, positive side, high in precharge |
| cmp_n | input | 1 | Comparator output, negative side, high in precharge |
| cmp_clk | output | 1 | Comparator phase: 1 precharge, 0 compare |
| valid | output | 1 | Comparator decision flag |
| timeout | output | 1 | One-cycle pulse when a compare is aborted |

## Verification
Two pairs of events can fall in the same cycle. The first pair is the arrival of a decision and the end of the minimum compare window. The bench provokes it by dropping a comparator output exactly SYNC_STAGES+1 cycles before the window closes, and also one cycle earlier, and it expects a compare of exactly MIN_CMP_CYC cycles in both cases. The second pair is a decision and the timeout limit. The bench places the decision in compare cycle TMO_CYC-1, where it must be accepted with `timeout` staying 0, and one cycle later, where the compare must abort with a single `timeout` pulse.

// File: rtl/cmpclk_pkg.sv
package cmpclk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_TRACK = 2'd1,
      ST_CMP   = 2'd2,
      ST_PRE   = 2'd3
   } cmpclk_state_e;
endpackage

// File: rtl/cmpclk_sync.sv
module cmpclk_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   if (STAGES < 0 || STAGES > 3) begin : g_bad_stages
      $error("cmpclk_sync: STAGES must be 0..3");
   end

   if (STAGES == 0) begin : g_bypass
      assign d_out = d_in;
   end else begin : g_chain
      logic [W-1:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
         end else begin
            pipe[0] <= d_in;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         end
      end
      assign d_out = pipe[STAGES-1];
   end
endmodule

// File: rtl/cmpclk_window.sv
module cmpclk_window #(
   parameter int MIN_CYC = 50,
   parameter int TMO_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic win_ok,
   output logic tmo_hit
);
   localparam int CW = $clog2(TMO_CYC + 1);
   localparam logic [CW-1:0] MIN_LAST = CW'(MIN_CYC - 1);
   localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);

   if (MIN_CYC < 1 || TMO_CYC <= MIN_CYC) begin : g_bad_window
      $error("cmpclk_window: need 1 <= MIN_CYC < TMO_CYC");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run)             cnt_q <= '0;
      else if (cnt_q != TMO_LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign win_ok  = (cnt_q >= MIN_LAST);
   assign tmo_hit = (cnt_q == TMO_LAST);

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= TMO_LAST);
endmodule

// File: rtl/cmpclk_gen.sv
module cmpclk_gen
   import cmpclk_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int TRACK_CYC   = 4,
   parameter int MIN_CMP_CYC = 50,
   parameter int TMO_CYC     = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_start,
   input  logic bit_en,
   input  logic cmp_p,
   input  logic cmp_n,
   output logic cmp_clk,
   output logic valid,
   output logic timeout
);
   localparam int TW = (TRACK_CYC < 2) ? 1 : $clog2(TRACK_CYC);
   localparam logic [TW-1:0] TRK_LOAD = TW'(TRACK_CYC - 1);

   if (TRACK_CYC < 1) begin : g_bad_track
      $error("cmpclk_gen: TRACK_CYC must be at least 1");
   end

   cmpclk_state_e state_q, state_d;
   logic [TW-1:0] trk_q;
   logic [1:0]    cmp_s;
   logic          nand_s, win_ok, tmo_hit;
   logic          cmp_clk_q, timeout_q;

   cmpclk_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({cmp_p, cmp_n}),
      .d_out (cmp_s)
   );

   cmpclk_window #(.MIN_CYC(MIN_CMP_CYC), .TMO_CYC(TMO_CYC)) u_win (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_CMP),
      .win_ok  (win_ok),
      .tmo_hit (tmo_hit)
   );

   assign nand_s = ~(cmp_s[1] & cmp_s[0]);

   always_comb begin
      unique case (state_q)
         ST_CMP:  valid = nand_s & win_ok;
         ST_PRE:  valid = nand_s;
         default: valid = 1'b0;
      endcase
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (conv_start) state_d = ST_TRACK;
         ST_TRACK: if (trk_q == '0) state_d = ST_CMP;
         ST_CMP: begin
            if (valid)        state_d = ST_PRE;
            else if (tmo_hit) state_d = ST_IDLE;
         end
         ST_PRE:   if (!valid) state_d = bit_en ? ST_CMP : ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         trk_q     <= '0;
         cmp_clk_q <= 1'b1;
         timeout_q <= 1'b0;
      end else begin
         state_q   <= state_d;
         cmp_clk_q <= (state_d != ST_CMP);
         timeout_q <= (state_q == ST_CMP) && tmo_hit && !valid;
         if (state_q == ST_IDLE)  trk_q <= TRK_LOAD;
         else if (state_q == ST_TRACK && trk_q != '0) trk_q <= trk_q - 1'b1;
      end
   end

   assign cmp_clk = cmp_clk_q;
   assign timeout = timeout_q;

   // R1
   idle_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> (cmp_clk_q && !valid));
   // R4
   min_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_clk_q && !win_ok) |=> !cmp_clk_q);
   // R3
   masked_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_clk_q && valid) |-> win_ok);
   // R4
   rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmp_clk_q) |-> ($past(valid) || timeout_q));
   // R7
   timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_q |=> !timeout_q);
   // R7
   timeout_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_q |-> (cmp_clk_q && state_q == ST_IDLE));
endmodule

// File: tb/cmpclk_gen_tb.sv
`timescale 1ns/1ps
module cmpclk_gen_tb;
   localparam int S    = 2;
   localparam int TRK  = 3;
   localparam int MINC = 6;
   localparam int TMO  = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conv_start = 1'b0;
   logic bit_en = 1'b0;
   logic cmp_p = 1'b1;
   logic cmp_n = 1'b1;
   logic cmp_clk, valid, timeout;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int knob_k = 0, knob_r = 0;
   bit knob_side = 1'b0;
   int k_l = 0, r_l = 0, lo_cnt = 0, hi_cnt = 0;
   bit side_l = 1'b0;

   always #2.5 clk = ~clk;

   cmpclk_gen #(.SYNC_STAGES(S), .TRACK_CYC(TRK), .MIN_CMP_CYC(MINC), .TMO_CYC(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .bit_en(bit_en),
      .cmp_p(cmp_p), .cmp_n(cmp_n), .cmp_clk(cmp_clk), .valid(valid), .timeout(timeout)
   );

   // Behavioural comparator: decides k cycles into compare, recovers r cycles into precharge
   always @(negedge clk) begin
      if (cmp_clk) begin
         lo_cnt <= 0;
         k_l    <= knob_k;
         side_l <= knob_side;
         if (hi_cnt >= r_l) begin cmp_p <= 1'b1; cmp_n <= 1'b1; end
         hi_cnt <= hi_cnt + 1;
      end else begin
         hi_cnt <= 0;
         r_l    <= knob_r;
         if (lo_cnt >= k_l) begin
            if (side_l) cmp_n <= 1'b0; else cmp_p <= 1'b0;
         end
         lo_cnt <= lo_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_low(input int k);
      return (k + S + 1 > MINC) ? (k + S + 1) : MINC;
   endfunction

   function automatic bit will_timeout(input int k);
      return (k + S >= TMO);
   endfunction

   task automatic run_conv(input int nbits, input int kfix, input bit poke);
      int hi, lo, vcnt, kb, rb;
      bit vlast;
      knob_k    = (kfix < 0) ? int'($urandom_range(12, 0)) : kfix;
      knob_side = 1'($urandom_range(1, 0));
      bit_en    = (nbits > 1);
      @(negedge clk) conv_start = 1'b1;
      @(negedge clk) conv_start = 1'b0;
      hi = 0;
      while (cmp_clk === 1'b1 && hi < 50) begin hi++; @(negedge clk); end
      chk(hi == TRK, "R2 track length", hi, TRK);
      for (int b = 0; b < nbits; b++) begin
         kb = knob_k;
         bit_en = (b < nbits - 1);
         knob_r = int'($urandom_range(4, 0));
         rb = knob_r;
         lo = 0; vcnt = 0; vlast = 1'b0;
         while (cmp_clk === 1'b0 && lo < TMO + 5) begin
            conv_start = (poke && b == 0 && lo == 1);
            vcnt += int'(valid);
            vlast = valid;
            lo++;
            @(negedge clk);
         end
         conv_start = 1'b0;
         if (will_timeout(kb)) begin
            chk(lo == TMO, "R7 aborted compare length", lo, TMO);
            chk(vcnt == 0, "R7 no valid before abort", vcnt, 0);
            chk(timeout == 1'b1, "R7 timeout pulse", int'(timeout), 1);
            @(negedge clk);
            chk(timeout == 1'b0, "R7 timeout single cycle", int'(timeout), 0);
            chk(cmp_clk == 1'b1, "R7 precharge after abort", int'(cmp_clk), 1);
            return;
         end
         chk(lo == exp_low(kb), poke ? "R8 compare length with busy start" : "R4 compare length",
             lo, exp_low(kb));
         chk(vcnt == 1 && vlast, "R3 valid only in last compare cycle", vcnt, 1);
         chk(valid == 1'b1, "R3 valid unmasked in precharge", int'(valid), 1);
         chk(timeout == 1'b0, "R7 no timeout on normal bit", int'(timeout), 0);
         knob_k    = (kfix < 0) ? int'($urandom_range(12, 0)) : kfix;
         knob_side = 1'($urandom_range(1, 0));
         hi = 0;
         while (cmp_clk === 1'b1 && hi < 12) begin hi++; @(negedge clk); end
         if (b < nbits - 1)
            chk(hi == rb + S + 1, "R5 precharge length", hi, rb + S + 1);
         else begin
            chk(hi == 12, "R6 stays in precharge after last bit", hi, 12);
            chk(valid == 1'b0, "R6 valid low when idle", int'(valid), 0);
         end
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24681));
      repeat (4) @(negedge clk);
      chk(cmp_clk == 1'b1, "R1 reset cmp_clk", int'(cmp_clk), 1);
      chk(valid == 1'b0, "R1 reset valid", int'(valid), 0);
      chk(timeout == 1'b0, "R1 reset timeout", int'(timeout), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(cmp_clk == 1'b1, "R1 idle cmp_clk", int'(cmp_clk), 1);
      // directed: decision lands as the window closes, and one cycle earlier
      run_conv(3, MINC - S - 1, 1'b0);
      run_conv(2, MINC - S - 2, 1'b0);
      // directed: decision in the last allowed cycle, then one past it
      run_conv(2, TMO - S - 1, 1'b0);
      run_conv(3, TMO - S, 1'b0);
      // directed: start pulse during compare ignored
      run_conv(2, 9, 1'b1);
      run_conv(1, 0, 1'b0);
      for (int i = 0; i < 40; i++)
         run_conv(int'($urandom_range(10, 1)), -1, 1'($urandom_range(1, 0)));
      repeat (4) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule